// File: doc/BRIEF.md
# Temporal Stream Follower Buffer

This block replays a stretch of a previously recorded miss-address log as a prefetch stream. When a stream start arrives carrying the log position of the miss that triggered it, the block reads the entries recorded after that position. It queues the addresses in order and sends them out as prefetch requests. Issue is throttled, so only a small number of streamed blocks can be in flight at any time.

Prefetched data returns through a fill port. It lands in a small fully associative holding buffer that sits beside the first-level cache. A processor miss probes this buffer through the lookup port. A match answers the miss and frees the entry. Each consumed block lets the stream advance by one more prefetch.

A later stream start abandons whatever the earlier stream still had queued or being read from the log. Blocks that were already fetched stay available. An invalidate port removes a stale block by address.

Top module: `tsf_follower`

## Requirements
- R1: A stream start carrying log index s makes the block read the log beginning at index s+1 on the next cycle and then at consecutive indices. The entry at index s is never queued.
- R2: Prefetch requests leave in the same order as the log entries they were read from. A request that is not accepted keeps `pf_req_valid` high and `pf_req_addr` unchanged until it is accepted or a new stream starts.
- R3: Every fill is stored in a fully associative buffer of `SVB_N` entries. A fill whose address is already present overwrites that entry, so no duplicate is created.
- R4: A lookup gets its response exactly one cycle later. `lk_resp_hit` is 1 with the stored data when the address is held, and 0 otherwise.
- R5: At most `MAX_INFLIGHT` prefetches issued since the latest stream start can be outstanding without having been consumed by a lookup hit.
- R6: Each lookup hit returns one issue credit, so exactly one more queued address can then be issued.
- R7: A lookup hit removes the entry, and a repeat lookup of that address misses.
- R8: A fill that needs a new entry takes a free entry when one exists. Only when the buffer is full does it replace the entry filled longest ago.
- R9: A new stream start empties the address queue, discards log reads still in flight, and resets the issue credits to full. Blocks already in the buffer stay valid.
- R10: An invalidate removes any buffer entry with that address. A fill to the same address in the same cycle is dropped.
- R11: After reset the buffer is empty, no log read is made before the first stream start, and no prefetch or lookup response is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Begin a new stream |
| start_idx | input | 16 | Log index of the miss that triggered the stream |
| log_rd_en | output | 1 | Log read request |
| log_rd_idx | output | 16 | Log index being read |
| log_rsp_valid | input | 1 | Log read response, in request order |
| log_rsp_addr | input | 32 | Block address stored at the requested index |
| pf_req_valid | output | 1 | Prefetch request valid |
| pf_req_addr | output | 32 | Block address to prefetch |
| pf_req_ready | input | 1 | Prefetch request accepted this cycle |
| fill_valid | input | 1 | Fill data arriving |
| fill_addr | input | 32 | Fill block address |
| fill_data | input | 64 | Fill data |
| inv_valid | input | 1 | Invalidate a block |
| inv_addr | input | 32 | Block address to invalidate |
| lk_valid | input | 1 | Processor miss lookup |
| lk_addr | input | 32 | Lookup block address |
| lk_resp_valid | output | 1 | Lookup response, one cycle after the lookup |
| lk_resp_hit | output | 1 | Lookup found the block |
| lk_resp_data | output | 64 | Block data on a hit, zero on a miss |

## Verification
The properties assume that the log answers each read exactly once, in request order, and never sends a response that was not asked for. They also assume that the lookup, invalidate and fill strobes are single-cycle qualifiers of their address fields. The bench log model answers every read one cycle after the request and returns a distinct computed address for every index, so a stale or misordered entry shows up as a wrong prefetch address. Fills, lookups and invalidates come only from driver tasks that hold each strobe for one cycle. The acceptance side is stalled only on purpose, and the stall is always released.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int IDX_W  = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } blk_t;

    typedef struct packed {
        logic  hit;
        data_t data;
    } lk_rsp_t;

    // bits needed to hold the values 0..n
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

    // bits needed to index n entries, at least one
    function automatic int ptr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tsf_stream_fifo.sv
module tsf_stream_fifo
    import tsf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = ptr_w(DEPTH),
    localparam int CW = cnt_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  addr_t         push_addr,
    input  logic          pop,
    output logic          empty,
    output logic [CW-1:0] count,
    output addr_t         head
);
    addr_t         mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt != CW'(DEPTH));
    assign do_pop  = pop && (cnt != '0);
    assign empty   = (cnt == '0);
    assign count   = cnt;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_addr;
                wr_ptr      <= step(wr_ptr);
            end
            if (do_pop)
                rd_ptr <= step(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/tsf_log_reader.sv
module tsf_log_reader
    import tsf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = cnt_w(DEPTH),
    localparam int OW = cnt_w(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_valid,
    input  idx_t          start_idx,
    input  logic [CW-1:0] q_count,
    output logic          log_rd_en,
    output idx_t          log_rd_idx,
    input  logic          log_rsp_valid,
    input  addr_t         log_rsp_addr,
    output logic          push,
    output addr_t         push_addr
);
    logic          active;
    idx_t          nxt_idx;
    logic [OW-1:0] rd_out;   // reads requested and not yet answered
    logic [OW-1:0] drop_n;   // of those, answers that belong to a dead stream
    logic [OW-1:0] live;
    logic          room, keep;

    assign live       = rd_out - drop_n;
    assign room       = (OW'(q_count) + live) < OW'(DEPTH);
    assign log_rd_en  = active && !start_valid && room;
    assign log_rd_idx = nxt_idx;
    assign keep       = log_rsp_valid && (drop_n == '0);
    assign push       = keep && !start_valid;
    assign push_addr  = log_rsp_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            nxt_idx <= '0;
            rd_out  <= '0;
            drop_n  <= '0;
        end else if (start_valid) begin
            active  <= 1'b1;
            nxt_idx <= start_idx + 1'b1;
            rd_out  <= rd_out - OW'(log_rsp_valid);
            drop_n  <= rd_out - OW'(log_rsp_valid);
        end else begin
            if (log_rd_en)
                nxt_idx <= nxt_idx + 1'b1;
            rd_out <= rd_out + OW'(log_rd_en) - OW'(log_rsp_valid);
            if (log_rsp_valid && (drop_n != '0))
                drop_n <= drop_n - 1'b1;
        end
    end
endmodule

// File: rtl/tsf_pacer.sv
module tsf_pacer
    import tsf_pkg::*;
#(
    parameter int MAX_INFLIGHT = 4,
    localparam int CW = cnt_w(MAX_INFLIGHT)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic issue,
    input  logic credit_ret,
    output logic may_issue
);
    logic [CW-1:0] used;

    assign may_issue = (used < CW'(MAX_INFLIGHT));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            used <= '0;
        end else begin
            unique case ({issue, credit_ret})
                2'b10:   used <= used + 1'b1;
                2'b01:   if (used != '0) used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end
endmodule

// File: rtl/tsf_value_buf.sv
module tsf_value_buf
    import tsf_pkg::*;
#(
    parameter int N = 32,
    localparam int SW = ptr_w(N)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fill_valid,
    input  blk_t    fill_blk,
    input  logic    inv_valid,
    input  addr_t   inv_addr,
    input  logic    lk_valid,
    input  addr_t   lk_addr,
    output logic    consume,
    output logic    rsp_valid,
    output lk_rsp_t rsp
);
    logic [N-1:0] vld;
    addr_t        tag   [N];
    data_t        dat   [N];
    logic [N-1:0] older [N];   // older[i][j]: entry i was filled before entry j

    logic [N-1:0]  lk_m, inv_m, fill_m, oldest_v;
    logic [SW-1:0] free_idx, old_idx, match_idx, tgt;
    logic          free_any, do_fill;
    data_t         hit_data;

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        logic [N-1:0] self_bit;
        assign self_bit     = N'(1) << gi;
        assign lk_m[gi]     = lk_valid && vld[gi] && (tag[gi] == lk_addr);
        assign inv_m[gi]    = inv_valid && vld[gi] && (tag[gi] == inv_addr);
        assign fill_m[gi]   = vld[gi] && (tag[gi] == fill_blk.addr);
        assign oldest_v[gi] = vld[gi] && ((older[gi] | ~vld | self_bit) == {N{1'b1}});
    end

    always_comb begin
        free_any  = 1'b0;
        free_idx  = '0;
        old_idx   = '0;
        match_idx = '0;
        hit_data  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = SW'(i);
            end
            if (oldest_v[i]) old_idx = SW'(i);
            if (fill_m[i])   match_idx = SW'(i);
            if (lk_m[i])     hit_data = hit_data | dat[i];
        end
        if (|fill_m)       tgt = match_idx;
        else if (free_any) tgt = free_idx;
        else               tgt = old_idx;
    end

    assign do_fill = fill_valid && !(inv_valid && (inv_addr == fill_blk.addr));
    assign consume = |lk_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld       <= '0;
            rsp_valid <= 1'b0;
            rsp       <= '0;
            for (int i = 0; i < N; i++) older[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (lk_m[i] || inv_m[i])
                    vld[i] <= 1'b0;
                if (do_fill && (tgt == SW'(i))) begin
                    vld[i] <= 1'b1;
                    tag[i] <= fill_blk.addr;
                    dat[i] <= fill_blk.data;
                end
                for (int j = 0; j < N; j++) begin
                    if (do_fill) begin
                        if (tgt == SW'(i))      older[i][j] <= 1'b0;
                        else if (tgt == SW'(j)) older[i][j] <= 1'b1;
                    end
                end
            end
            rsp_valid <= lk_valid;
            rsp.hit   <= consume;
            rsp.data  <= hit_data;
        end
    end
endmodule

// File: rtl/tsf_follower.sv
module tsf_follower
    import tsf_pkg::*;
#(
    parameter int SQ_DEPTH     = 8,
    parameter int SVB_N        = 32,
    parameter int MAX_INFLIGHT = 4,
    localparam int QCW = cnt_w(SQ_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_valid,
    input  logic [IDX_W-1:0]       start_idx,
    output logic                   log_rd_en,
    output logic [IDX_W-1:0]       log_rd_idx,
    input  logic                   log_rsp_valid,
    input  logic [ADDR_W-1:0]      log_rsp_addr,
    output logic                   pf_req_valid,
    output logic [ADDR_W-1:0]      pf_req_addr,
    input  logic                   pf_req_ready,
    input  logic                   fill_valid,
    input  logic [ADDR_W-1:0]      fill_addr,
    input  logic [DATA_W-1:0]      fill_data,
    input  logic                   inv_valid,
    input  logic [ADDR_W-1:0]      inv_addr,
    input  logic                   lk_valid,
    input  logic [ADDR_W-1:0]      lk_addr,
    output logic                   lk_resp_valid,
    output logic                   lk_resp_hit,
    output logic [DATA_W-1:0]      lk_resp_data
);
    logic           q_push, q_empty, issue, may_issue, consume;
    addr_t          q_push_addr, q_head;
    logic [QCW-1:0] q_count;
    blk_t           fill_blk;
    lk_rsp_t        rsp;

    tsf_log_reader #(.DEPTH(SQ_DEPTH)) u_rd (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_idx(start_idx),
        .q_count(q_count),
        .log_rd_en(log_rd_en), .log_rd_idx(log_rd_idx),
        .log_rsp_valid(log_rsp_valid), .log_rsp_addr(log_rsp_addr),
        .push(q_push), .push_addr(q_push_addr)
    );

    tsf_stream_fifo #(.DEPTH(SQ_DEPTH)) u_q (
        .clk(clk), .rst(rst), .flush(start_valid),
        .push(q_push), .push_addr(q_push_addr),
        .pop(issue), .empty(q_empty), .count(q_count), .head(q_head)
    );

    tsf_pacer #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_pace (
        .clk(clk), .rst(rst), .start(start_valid),
        .issue(issue), .credit_ret(consume), .may_issue(may_issue)
    );

    assign pf_req_valid = !q_empty && may_issue && !start_valid;
    assign pf_req_addr  = q_head;
    assign issue        = pf_req_valid && pf_req_ready;

    assign fill_blk.addr = fill_addr;
    assign fill_blk.data = fill_data;

    tsf_value_buf #(.N(SVB_N)) u_svb (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_blk(fill_blk),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .consume(consume), .rsp_valid(lk_resp_valid), .rsp(rsp)
    );

    assign lk_resp_hit  = rsp.hit;
    assign lk_resp_data = rsp.data;
endmodule

// File: rtl/tsf_follower_chk.sv
module tsf_follower_chk
    import tsf_pkg::*;
#(
    parameter int MAX_INFLIGHT = 4,
    localparam int CW = cnt_w(MAX_INFLIGHT) + 1
) (
    input logic  clk,
    input logic  rst,
    input logic  start_valid,
    input idx_t  start_idx,
    input logic  log_rd_en,
    input idx_t  log_rd_idx,
    input logic  pf_req_valid,
    input logic  pf_req_ready,
    input addr_t pf_req_addr,
    input logic  fill_valid,
    input logic  inv_valid,
    input addr_t inv_addr,
    input logic  lk_valid,
    input addr_t lk_addr,
    input logic  lk_resp_valid,
    input logic  lk_resp_hit
);
    logic [CW-1:0] seen;

    // issues since the latest start, less hits reported on the response port
    always_ff @(posedge clk) begin
        if (rst || start_valid) begin
            seen <= '0;
        end else begin
            case ({pf_req_valid && pf_req_ready, lk_resp_hit})
                2'b10:   seen <= seen + 1'b1;
                2'b01:   if (seen != '0) seen <= seen - 1'b1;
                default: seen <= seen;
            endcase
        end
    end

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!lk_resp_valid && !pf_req_valid && !log_rd_en));

    // R1
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        start_valid |=> (start_valid || (log_rd_en && (log_rd_idx == $past(start_idx) + 1'b1))));

    // R2
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (pf_req_valid && !pf_req_ready && !start_valid) |=>
            (start_valid || (pf_req_valid && $stable(pf_req_addr))));

    // R4
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_resp_valid);

    // R4
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_resp_valid);

    // R5
    pace_limit_chk: assert property (@(posedge clk) disable iff (rst)
        pf_req_valid |-> (seen < CW'(MAX_INFLIGHT) + CW'(lk_resp_hit)));

    // R7
    hit_removes_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_valid) && lk_valid && (lk_addr == $past(lk_addr)) && !$past(fill_valid))
            |=> !lk_resp_hit);

    // R10
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(inv_valid) && lk_valid && (lk_addr == $past(inv_addr))) |=> !lk_resp_hit);
endmodule

bind tsf_follower tsf_follower_chk #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_chk (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_idx(start_idx),
    .log_rd_en(log_rd_en), .log_rd_idx(log_rd_idx),
    .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready), .pf_req_addr(pf_req_addr),
    .fill_valid(fill_valid),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_resp_valid(lk_resp_valid), .lk_resp_hit(lk_resp_hit)
);

// File: tb/sim_tsf_follower.sv
`timescale 1ns/1ps
module sim_tsf_follower;
    import tsf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic  start_valid = 0; idx_t start_idx = '0;
    logic  log_rd_en; idx_t log_rd_idx;
    logic  log_rsp_valid = 0; addr_t log_rsp_addr = '0;
    logic  pf_req_valid; addr_t pf_req_addr; logic pf_req_ready = 1;
    logic  fill_valid = 0; addr_t fill_addr = '0; data_t fill_data = '0;
    logic  inv_valid = 0; addr_t inv_addr = '0;
    logic  lk_valid = 0; addr_t lk_addr = '0;
    logic  lk_resp_valid, lk_resp_hit; data_t lk_resp_data;

    tsf_follower #(.SQ_DEPTH(8), .SVB_N(8), .MAX_INFLIGHT(4)) u0 (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_idx(start_idx),
        .log_rd_en(log_rd_en), .log_rd_idx(log_rd_idx),
        .log_rsp_valid(log_rsp_valid), .log_rsp_addr(log_rsp_addr),
        .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr), .pf_req_ready(pf_req_ready),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_resp_valid(lk_resp_valid), .lk_resp_hit(lk_resp_hit), .lk_resp_data(lk_resp_data)
    );

    function automatic addr_t logf(input int i);
        return 32'h4000_0000 + addr_t'(i) * 32'h40;
    endfunction
    function automatic data_t datf(input addr_t a);
        return {a ^ 32'h5a5a_0000, ~a};
    endfunction

    // log memory model: one-cycle, in-order answers
    always @(posedge clk) begin
        log_rsp_valid <= log_rd_en;
        log_rsp_addr  <= logf(int'(log_rd_idx));
    end

    int n_chk = 0, n_fail = 0, pf_seen = 0;
    addr_t exp_pf[$];
    logic  exp_hit[$];
    data_t exp_dat[$];
    string exp_req[$];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares issued prefetches and lookup responses with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (pf_req_valid && pf_req_ready) begin
                pf_seen++;
                if (exp_pf.size() == 0) chk(0, "R2 unexpected prefetch", pf_req_addr, 0);
                else begin
                    automatic addr_t e = exp_pf.pop_front();
                    chk(pf_req_addr == e, "R1 R2 issue order", pf_req_addr, e);
                end
            end
            if (lk_resp_valid) begin
                if (exp_hit.size() == 0) chk(0, "R4 unexpected response", lk_resp_hit, 0);
                else begin
                    automatic logic  eh = exp_hit.pop_front();
                    automatic data_t ed = exp_dat.pop_front();
                    automatic string er = exp_req.pop_front();
                    chk(lk_resp_hit == eh && (!eh || lk_resp_data == ed), er,
                        {63'd0, lk_resp_hit, lk_resp_data}, {63'd0, eh, ed});
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_stream(input int s);
        @(posedge clk); #1;
        exp_pf.delete();
        for (int k = 1; k <= 40; k++) exp_pf.push_back(logf(s + k));
        start_valid = 1; start_idx = idx_t'(s);
        @(posedge clk); #1;
        start_valid = 0;
    endtask

    task automatic lookup(input addr_t a, input logic h, input data_t d, input string req);
        @(posedge clk); #1;
        exp_hit.push_back(h); exp_dat.push_back(d); exp_req.push_back(req);
        lk_valid = 1; lk_addr = a;
        @(posedge clk); #1;
        lk_valid = 0;
    endtask

    task automatic fill(input addr_t a, input data_t d);
        @(posedge clk); #1;
        fill_valid = 1; fill_addr = a; fill_data = d;
        @(posedge clk); #1;
        fill_valid = 0;
    endtask

    task automatic inval(input addr_t a, input bit with_fill);
        @(posedge clk); #1;
        inv_valid = 1; inv_addr = a;
        if (with_fill) begin fill_valid = 1; fill_addr = a; fill_data = datf(a); end
        @(posedge clk); #1;
        inv_valid = 0; fill_valid = 0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 0);
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(5);
        @(negedge clk);
        // R11: quiet after reset
        chk(!log_rd_en && !pf_req_valid && !lk_resp_valid, "R11 idle after reset",
            {log_rd_en, pf_req_valid, lk_resp_valid}, 0);
        lookup(logf(11), 0, '0, "R11 empty buffer miss");

        // R1 R2 R5: stream from index 10, four issues only
        start_stream(10);
        cyc(40);
        chk(pf_seen == 4, "R5 credit limit", pf_seen, 4);

        for (int k = 11; k <= 14; k++) fill(logf(k), datf(logf(k)));
        lookup(logf(11), 1, datf(logf(11)), "R4 hit data");
        cyc(10);
        chk(pf_seen == 5, "R6 one issue per hit", pf_seen, 5);
        lookup(logf(11), 0, '0, "R7 entry removed");
        lookup(logf(200), 0, '0, "R4 miss unknown");

        // R2 hold under stall
        pf_req_ready = 0;
        lookup(logf(12), 1, datf(logf(12)), "R4 hit second");
        cyc(3);
        @(negedge clk);
        chk(pf_req_valid && pf_req_addr == logf(16), "R2 held request", pf_req_addr, logf(16));
        cyc(1);
        @(negedge clk);
        chk(pf_req_valid && pf_req_addr == logf(16), "R2 still held", pf_req_addr, logf(16));
        @(posedge clk); #1;
        pf_req_ready = 1;
        cyc(5);
        chk(pf_seen == 6, "R6 stalled issue counted", pf_seen, 6);

        // R10 invalidate
        inval(logf(13), 0);
        lookup(logf(13), 0, '0, "R10 invalidated");

        // R9 restart
        start_stream(100);
        cyc(40);
        chk(pf_seen == 10, "R9 credits reset", pf_seen, 10);
        lookup(logf(14), 1, datf(logf(14)), "R9 buffer kept");
        cyc(10);
        chk(pf_seen == 11, "R6 hit on kept block", pf_seen, 11);

        // R3 overwrite
        fill(32'h7000_0040, 64'h1111);
        fill(32'h7000_0040, 64'h2222);
        lookup(32'h7000_0040, 1, 64'h2222, "R3 overwrite");
        lookup(32'h7000_0040, 0, '0, "R3 no duplicate");

        // R10 same-cycle fill dropped
        inval(32'h7000_0080, 1);
        lookup(32'h7000_0080, 0, '0, "R10 fill dropped");

        // R8 oldest replaced, free slot first
        for (int k = 0; k < 9; k++) fill(32'h6000_0000 + addr_t'(k) * 32'h40, datf(32'h6000_0000 + addr_t'(k) * 32'h40));
        lookup(32'h6000_0000, 0, '0, "R8 oldest evicted");
        lookup(32'h6000_0200, 1, datf(32'h6000_0200), "R8 newest kept");
        lookup(32'h6000_0040, 1, datf(32'h6000_0040), "R8 second kept");
        fill(32'h6000_0400, datf(32'h6000_0400));
        lookup(32'h6000_0080, 1, datf(32'h6000_0080), "R8 free slot used first");
        lookup(32'h6000_0400, 1, datf(32'h6000_0400), "R8 new fill present");

        cyc(4);
        chk(exp_hit.size() == 0, "R4 all responses seen", exp_hit.size(), 0);
        summary();
        $finish;
    end
endmodule